// File: doc/BRIEF.md
# Register Shift Execute Unit

This unit executes the shift instructions of a 16-bit register machine. Each cycle it receives one 32-bit instruction word and the two operand values the register file returns for the indices the unit presents. It decodes the opcode, then shifts the first operand by an amount taken either from an immediate nibble or from the low four bits of the second operand. It has one registered stage, which holds the result, the destination index, a write strobe, and the zero and negative condition flags.

The instruction word carries its first byte in bits 31:24, which hold the opcode. The second byte, in bits 23:16, holds the source/destination register index X in its low nibble (bits 19:16). The register forms also place the amount register index Y in the high nibble of that byte (bits 23:20). The third byte, in bits 15:8, holds the immediate amount N in its low nibble (bits 11:8). Bytes an instruction does not use are expected to be zero, and the unit does not check them. Arithmetic left shift has no opcode of its own, because it gives the same result as logical left shift.

Top module: `shift_exec_unit`

## Requirements
- R1: While reset is asserted, `wr_en`, `wr_data`, `wr_idx`, `flag_z` and `flag_n` are all zero.
- R2: `rx_idx` always equals instruction bits 19:16 and `ry_idx` always equals bits 23:20, with no delay.
- R3: Opcode 0xB0 shifts the X operand left by the immediate N from bits 11:8, filling with zeros.
- R4: Opcode 0xB1 shifts the X operand right by the immediate N, filling with zeros.
- R5: Opcode 0xB2 shifts the X operand right by the immediate N and copies bit 15 into the vacated positions.
- R6: Opcodes 0xB3, 0xB4 and 0xB5 perform left, logical right and arithmetic right shifts, using the low four bits of the Y operand as the amount and ignoring its upper bits.
- R7: After each executed shift, `flag_z` is 1 exactly when the 16-bit result is zero.
- R8: After each executed shift, `flag_n` equals bit 15 of the result.
- R9: A shift amount of zero returns the X operand unchanged, and the flags are set from that value.
- R10: An opcode outside 0xB0–0xB5 raises no `wr_en` and leaves both flags at their previous values.
- R11: `wr_en` rises in the cycle after a valid recognised instruction is presented and is low otherwise. `wr_idx` equals the X index of that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word, opcode in bits 31:24 |
| rx_val | input | 16 | Register file value at `rx_idx` |
| ry_val | input | 16 | Register file value at `ry_idx` |
| rx_idx | output | 4 | Read index for the operand to shift |
| ry_idx | output | 4 | Read index for the amount register |
| wr_en | output | 1 | Write-back strobe |
| wr_idx | output | 4 | Write-back register index |
| wr_data | output | 16 | Shifted result |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
The hardest case to reach is the flag hold on an unrecognised opcode. It can only be seen when the flags already hold values that a new result would have overwritten. The bench therefore first runs a shift that sets the negative flag, then presents opcode 0xB6 with an operand whose shift would have cleared that flag. It then checks that the flags did not move and that no write occurred. Register-amount vectors place ones in the upper bits of the Y operand, so that a failure to mask the amount shows up as a wrong result.

// File: rtl/shift_exec_unit.sv
module shift_exec_unit #(
  parameter int DATA_W  = 16,
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  rx_val,
  input  logic [DATA_W-1:0]  ry_val,
  output logic [IDX_W-1:0]   rx_idx,
  output logic [IDX_W-1:0]   ry_idx,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [DATA_W-1:0]  wr_data,
  output logic               flag_z,
  output logic               flag_n
);
  localparam int AMT_W = $clog2(DATA_W);
  localparam logic [7:0] OP_SHL_I = 8'hB0;
  localparam logic [7:0] OP_SHR_I = 8'hB1;
  localparam logic [7:0] OP_SAR_I = 8'hB2;
  localparam logic [7:0] OP_SHL_R = 8'hB3;
  localparam logic [7:0] OP_SAR_R = 8'hB5;

  logic [7:0] opcode, byte1, byte2;
  assign opcode = instr[INSTR_W-1 -: 8];
  assign byte1  = instr[INSTR_W-9 -: 8];
  assign byte2  = instr[INSTR_W-17 -: 8];

  assign rx_idx = byte1[IDX_W-1:0];
  assign ry_idx = byte1[7 -: IDX_W];

  logic is_imm, is_reg, legal;
  assign is_imm = (opcode >= OP_SHL_I) && (opcode <= OP_SAR_I);
  assign is_reg = (opcode >= OP_SHL_R) && (opcode <= OP_SAR_R);
  assign legal  = is_imm || is_reg;

  logic [7:0]       kind_full;
  logic [1:0]       kind;
  logic [AMT_W-1:0] amt;
  assign kind_full = is_imm ? (opcode - OP_SHL_I) : (opcode - OP_SHL_R);
  assign kind      = kind_full[1:0];
  assign amt       = is_imm ? byte2[AMT_W-1:0] : ry_val[AMT_W-1:0];

  logic [DATA_W-1:0] result;
  always_comb begin
    case (kind)
      2'd0:    result = rx_val << amt;
      2'd1:    result = rx_val >> amt;
      2'd2:    result = DATA_W'($signed(rx_val) >>> amt);
      default: result = rx_val;
    endcase
  end

  logic fire;
  assign fire = instr_valid && legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      flag_z  <= 1'b0;
      flag_n  <= 1'b0;
    end else begin
      wr_en <= fire;
      if (fire) begin
        wr_idx  <= rx_idx;
        wr_data <= result;
        flag_z  <= (result == '0);
        flag_n  <= result[DATA_W-1];
      end
    end
  end

  a_r11_wr_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(instr_valid));
  a_r10_flags_move_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(flag_z) || !$stable(flag_n)) |-> wr_en);
  a_r7_zero_matches_result: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (flag_z == (wr_data == '0)));
  a_r8_neg_matches_msb: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (flag_n == wr_data[DATA_W-1]));
  a_r5_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(instr_valid && opcode == OP_SAR_I && rx_val[DATA_W-1])) |-> wr_data[DATA_W-1]);
  a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(instr_valid && opcode == OP_SHR_I && byte2[AMT_W-1:0] != '0)) |-> !wr_data[DATA_W-1]);
endmodule

// File: tb/shift_exec_unit_tb.sv
`timescale 1ns/1ps
module shift_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [15:0] rx_val = '0, ry_val = '0;
  logic [3:0]  rx_idx, ry_idx, wr_idx;
  logic        wr_en, flag_z, flag_n;
  logic [15:0] wr_data;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shift_exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .rx_val(rx_val), .ry_val(ry_val), .rx_idx(rx_idx), .ry_idx(ry_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .flag_z(flag_z), .flag_n(flag_n));

  // {op, x, y, n, rx, ry, expected}
  localparam int NV = 12;
  localparam logic [67:0] VEC [NV] = '{
    {8'hB0, 4'h1, 4'h0, 4'h4, 16'h1234, 16'h0000, 16'h2340},
    {8'hB1, 4'h2, 4'h0, 4'h4, 16'h8421, 16'h0000, 16'h0842},
    {8'hB2, 4'h3, 4'h0, 4'h4, 16'h8421, 16'h0000, 16'hF842},
    {8'hB3, 4'h4, 4'h5, 4'h0, 16'h0F0F, 16'h0013, 16'h7878},
    {8'hB4, 4'h5, 4'h6, 4'h0, 16'hF00F, 16'hFFF8, 16'h00F0},
    {8'hB5, 4'h6, 4'h7, 4'h0, 16'h8000, 16'h0021, 16'hC000},
    {8'hB0, 4'h7, 4'h0, 4'h0, 16'h8001, 16'h0000, 16'h8001},
    {8'hB0, 4'h8, 4'h0, 4'hF, 16'h0003, 16'h0000, 16'h8000},
    {8'hB1, 4'h9, 4'h0, 4'hF, 16'h8000, 16'h0000, 16'h0001},
    {8'hB2, 4'hA, 4'h0, 4'hF, 16'h8000, 16'h0000, 16'hFFFF},
    {8'hB4, 4'hB, 4'hC, 4'h0, 16'h0000, 16'h0010, 16'h0000},
    {8'hB1, 4'hF, 4'h0, 4'h1, 16'h0001, 16'h0000, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [3:0] x, input logic [3:0] y,
                       input logic [3:0] n, input logic [15:0] rx, input logic [15:0] ry);
    instr       = {op, y, x, 4'h0, n, 8'h00};
    rx_val      = rx;
    ry_val      = ry;
    instr_valid = 1'b1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 wr_en", wr_en, 0);
    check("R1 wr_data", wr_data, 0);
    check("R1 flags", {flag_z, flag_n}, 0);
    check("R1 wr_idx", wr_idx, 0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(8'hB4, 4'h3, 4'hA, 4'h0, 16'h0, 16'h0);
    #1;
    check("R2 rx_idx", rx_idx, 4'h3);
    check("R2 ry_idx", ry_idx, 4'hA);
    instr_valid = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [7:0] op;
      logic [15:0] exp;
      string tag;
      op  = VEC[i][67:60];
      exp = VEC[i][15:0];
      tag = (op == 8'hB0) ? "R3" : (op == 8'hB1) ? "R4" : (op == 8'hB2) ? "R5" : "R6";
      issue(op, VEC[i][59:56], VEC[i][55:52], VEC[i][51:48], VEC[i][47:32], VEC[i][31:16]);
      @(negedge clk);
      check(tag, wr_data, exp);
      check("R11 wr_en", wr_en, 1);
      check("R11 wr_idx", wr_idx, VEC[i][59:56]);
      check("R7 zero flag", flag_z, exp == 16'h0);
      check("R8 neg flag", flag_n, exp[15]);
    end

    issue(8'hB3, 4'h2, 4'h4, 4'h0, 16'h8001, 16'hFFF0);
    @(negedge clk);
    check("R9 result", wr_data, 16'h8001);
    check("R9 flags", {flag_z, flag_n}, 2'b01);

    issue(8'hB6, 4'h5, 4'h0, 4'h1, 16'h0000, 16'h0000);
    @(negedge clk);
    check("R10 wr_en", wr_en, 0);
    check("R10 flags", {flag_z, flag_n}, 2'b01);
    issue(8'h00, 4'h5, 4'h0, 4'h0, 16'h0000, 16'h0000);
    @(negedge clk);
    check("R10 wr_en op00", wr_en, 0);
    check("R10 flags op00", {flag_z, flag_n}, 2'b01);

    issue(8'hB0, 4'h1, 4'h0, 4'h1, 16'h0000, 16'h0000);
    instr_valid = 1'b0;
    @(negedge clk);
    check("R11 no valid", wr_en, 0);
    check("R11 flags kept", {flag_z, flag_n}, 2'b01);
    issue(8'hB0, 4'hE, 4'h0, 4'h1, 16'h0001, 16'h0000);
    #1;
    check("R11 before edge", wr_en, 0);
    @(negedge clk);
    instr_valid = 1'b0;
    check("R11 after edge", wr_en, 1);
    check("R11 idx", wr_idx, 4'hE);
    @(negedge clk);
    check("R11 drops", wr_en, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule